// File: doc/BRIEF.md
# Charge-Redistribution SAR Sequencer

This block holds the successive-approximation control for an N-bit converter built on a binary-weighted capacitor array. It drives one switch code per capacitor and one switch for comparator auto-zero. Each capacitor switch can be open, on the signal input, on the reference, or on ground. The comparator switch is closed while the array samples the input.

A start pulse ends sampling. The block then spends one cycle with every capacitor switch open, which traps the sampled charge and leaves the comparator floating. After that it tries the capacitors one per clock, from the most significant down. Each comparator decision either keeps the capacitor under test at reference or drops it to ground. The final switch positions form the output word. The word appears with a one-cycle done pulse, and the block then returns to sampling.

The analog array and comparator are outside the block. In use, a comparator output that is high means the trial level does not exceed the held input.

Top module: `sar_sequencer`

## Requirements
- R1: Out of reset and whenever idle, the sampling pattern is driven. The top capacitor (index N-1) has code 01 (signal) and every other capacitor has code 10 (reference). `az_closed` is 1, and `busy` and `done` are 0. Capacitor i uses `sw_code[2i+1:2i]`.
- R2: A start sampled high while idle moves the block to a hold cycle in the next cycle. In the hold cycle every capacitor code is 00 (open), `az_closed` is 0 and `busy` is 1.
- R3: The cycle after the hold cycle is the first trial. In it the top capacitor is at reference (10) and all lower capacitors are at ground (11).
- R4: Each trial takes exactly one clock, and no capacitor is on the signal input while `busy` is high. When `cmp_hi` is sampled high, the capacitor under test stays at reference; when it is low, that capacitor moves to ground. The next lower capacitor then goes to reference, and the ones below it stay at ground.
- R5: `done` is high for exactly one cycle, the cycle after the decision on capacitor 0. `busy` is low in that cycle.
- R6: In the done cycle, `result[i]` is 1 exactly when capacitor i is at reference. The switch codes still show the final positions.
- R7: A start while `busy` or `done` is high is ignored. It neither restarts nor lengthens the conversion, and the block returns to sampling as usual.
- R8: In the cycle after `done`, the sampling pattern of R1 is driven again and `az_closed` is 1.
- R9: `result` holds its value from one done cycle until the next done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request |
| cmp_hi | input | 1 | Comparator decision for the current trial |
| sw_code | output | 2*N | Per-capacitor switch code: 00 open, 01 signal, 10 reference, 11 ground |
| az_closed | output | 1 | Comparator auto-zero switch closed |
| busy | output | 1 | Hold or trial phase in progress |
| done | output | 1 | One-cycle strobe when the result is valid |
| result | output | N | Converted word, held between conversions |

## Verification
The bench checks the full-scale codes, zero, a lone MSB and alternating bit patterns. On each of these, a design that applied a decision to the wrong capacitor, or raised the next trial bit one position off, returns a shifted or stuck word. A start pulse is placed mid-conversion and another on the done cycle. A design that honoured either one would relaunch or stretch the conversion, and the hold and done timing would shift. Every trial cycle is compared against the expected switch pattern, so a design that skipped the open hold cycle would be caught. So would one that left the top capacitor on the signal input, or kept lower capacitors at reference.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned SAR_BITS_DEF = 12;

    typedef enum logic [1:0] {
        SW_OPEN = 2'b00,
        SW_SIG  = 2'b01,
        SW_REF  = 2'b10,
        SW_GND  = 2'b11
    } sw_pos_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_HOLD,
        PH_TRIAL,
        PH_DONE
    } phase_e;

    function automatic sw_pos_e trial_pos(input logic kept);
        return kept ? SW_REF : SW_GND;
    endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned N = SAR_BITS_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output phase_e              phase,
    output logic [$clog2(N)-1:0] idx
);
    localparam int unsigned IW = $clog2(N);
    localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SAMPLE;
            idx   <= '0;
        end else begin
            unique case (phase)
                PH_SAMPLE: if (start) phase <= PH_HOLD;
                PH_HOLD: begin
                    phase <= PH_TRIAL;
                    idx   <= TOP_IDX;
                end
                PH_TRIAL: begin
                    if (idx == '0) phase <= PH_DONE;
                    else           idx   <= idx - 1'b1;
                end
                PH_DONE:   phase <= PH_SAMPLE;
                default:   phase <= PH_SAMPLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_pkg::*;
#(
    parameter int unsigned N = SAR_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               phase,
    input  logic [$clog2(N)-1:0] idx,
    input  logic                 cmp_hi,
    output logic [N-1:0]         code,
    output logic [N-1:0]         word
);
    localparam logic [N-1:0] FIRST_TRIAL = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] code_nxt;

    always_comb begin
        code_nxt = code;
        if (!cmp_hi) code_nxt[idx] = 1'b0;
        if (idx != '0) code_nxt[idx - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            word <= '0;
        end else begin
            if (phase == PH_HOLD) begin
                code <= FIRST_TRIAL;
            end else if (phase == PH_TRIAL) begin
                code <= code_nxt;
                if (idx == '0) word <= code_nxt;
            end
        end
    end

endmodule

// File: rtl/sar_switch_map.sv
module sar_switch_map
    import sar_pkg::*;
#(
    parameter int unsigned N = SAR_BITS_DEF
) (
    input  phase_e           phase,
    input  logic [N-1:0]     code,
    output logic [2*N-1:0]   sw_code,
    output logic             az_closed
);
    for (genvar i = 0; i < N; i++) begin : g_cap
        sw_pos_e pos;
        always_comb begin
            unique case (phase)
                PH_SAMPLE: pos = (i == N - 1) ? SW_SIG : SW_REF;
                PH_HOLD:   pos = SW_OPEN;
                default:   pos = trial_pos(code[i]);
            endcase
        end
        assign sw_code[2*i +: 2] = pos;
    end

    assign az_closed = (phase == PH_SAMPLE);

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned N = SAR_BITS_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           cmp_hi,
    output logic [2*N-1:0] sw_code,
    output logic           az_closed,
    output logic           busy,
    output logic           done,
    output logic [N-1:0]   result
);
    localparam int unsigned IW = $clog2(N);

    phase_e        phase;
    logic [IW-1:0] idx;
    logic [N-1:0]  code;

    sar_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .idx   (idx)
    );

    sar_approx #(.N(N)) u_approx (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .idx    (idx),
        .cmp_hi (cmp_hi),
        .code   (code),
        .word   (result)
    );

    sar_switch_map #(.N(N)) u_map (
        .phase     (phase),
        .code      (code),
        .sw_code   (sw_code),
        .az_closed (az_closed)
    );

    assign busy = (phase == PH_HOLD) || (phase == PH_TRIAL);
    assign done = (phase == PH_DONE);

endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk
    import sar_pkg::*;
#(
    parameter int unsigned N = SAR_BITS_DEF
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [2*N-1:0] sw_code,
    input logic           az_closed,
    input logic           busy,
    input logic           done,
    input logic [N-1:0]   result
);
    logic any_sig;
    always_comb begin
        any_sig = 1'b0;
        for (int i = 0; i < N; i++)
            if (sw_code[2*i +: 2] == SW_SIG) any_sig = 1'b1;
    end

    p_sample_pattern_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> (az_closed && sw_code[2*N-1 -: 2] == SW_SIG));

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start) |=> busy);

    p_hold_open_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sw_code == '0 && !az_closed));

    p_first_trial_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> (sw_code[2*N-1 -: 2] == SW_REF));

    p_no_signal_busy_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !any_sig);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

    p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !busy);

    p_back_to_sample_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> az_closed);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

bind sar_sequencer sar_sequencer_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sw_code   (sw_code),
    .az_closed (az_closed),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
    localparam int N = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           cmp_hi;
    logic [2*N-1:0] sw_code;
    logic           az_closed, busy, done;
    logic [N-1:0]   result;
    logic [N-1:0]   vin = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sar_sequencer #(.N(N)) i_sar_sequencer (
        .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi),
        .sw_code(sw_code), .az_closed(az_closed), .busy(busy),
        .done(done), .result(result)
    );

    // Comparator stand-in: trial level taken from capacitors at reference.
    function automatic logic [N-1:0] ref_bits(input logic [2*N-1:0] s);
        logic [N-1:0] b;
        for (int i = 0; i < N; i++) b[i] = (s[2*i +: 2] == 2'b10);
        return b;
    endfunction
    assign cmp_hi = (ref_bits(sw_code) <= vin);

    function automatic logic [2*N-1:0] sample_pat();
        logic [2*N-1:0] p;
        for (int i = 0; i < N; i++) p[2*i +: 2] = (i == N - 1) ? 2'b01 : 2'b10;
        return p;
    endfunction

    function automatic logic [2*N-1:0] trial_pat(input logic [N-1:0] c);
        logic [2*N-1:0] p;
        for (int i = 0; i < N; i++) p[2*i +: 2] = c[i] ? 2'b10 : 2'b11;
        return p;
    endfunction

    function automatic logic [N-1:0] trial_code(input logic [N-1:0] v, input int k);
        logic [N-1:0] c;
        for (int i = 0; i < N; i++) c[i] = (i > k) ? v[i] : (i == k);
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [N-1:0] v, input bit pulse_mid, input bit pulse_done);
        @(negedge clk);
        vin = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sw_code == '0, "R2 hold switches open", sw_code, 0);
        chk(!az_closed && busy, "R2 hold az/busy", {az_closed, busy}, 2'b01);
        @(negedge clk);
        chk(sw_code == trial_pat({1'b1, {(N-1){1'b0}}}), "R3 first trial", sw_code,
            trial_pat({1'b1, {(N-1){1'b0}}}));
        for (int j = 0; j < N; j++) begin
            chk(busy && !done && sw_code == trial_pat(trial_code(v, N - 1 - j)), "R4 trial pattern",
                sw_code, trial_pat(trial_code(v, N - 1 - j)));
            start = pulse_mid && (j == 2);
            @(negedge clk);
        end
        start = 1'b0;
        chk(done && !busy, "R5 done pulse", {done, busy}, 2'b10);
        chk(result == v, "R6 result word", result, v);
        chk(sw_code == trial_pat(v), "R6 final positions", sw_code, trial_pat(v));
        if (pulse_mid) chk(done, "R7 mid-conversion start ignored", done, 1);
        start = pulse_done;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !busy, "R5 done one cycle", {done, busy}, 2'b00);
        chk(sw_code == sample_pat() && az_closed, "R8 back to sample", sw_code, sample_pat());
        if (pulse_done) chk(!busy, "R7 start at done ignored", busy, 0);
        repeat (2) @(negedge clk);
        chk(result == v && !busy, "R9 result held", result, v);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sw_code == sample_pat(), "R1 reset pattern", sw_code, sample_pat());
        chk(az_closed && !busy && !done, "R1 reset flags", {az_closed, busy, done}, 3'b100);
        chk(result == '0, "R1 reset result", result, 0);
        convert('0, 1'b0, 1'b0);
        convert('1, 1'b1, 1'b0);
        convert({1'b1, {(N-1){1'b0}}}, 1'b0, 1'b1);
        convert(N'(12'h555), 1'b1, 1'b1);
        convert(N'(12'hAAA), 1'b0, 1'b0);
        convert(N'(1), 1'b0, 1'b1);
        for (int r = 0; r < 24; r++) begin
            logic [N-1:0] v;
            v = N'($urandom);
            convert(v, ($urandom % 3) == 0, ($urandom % 3) == 0);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule